// File: doc/BRIEF.md
# Staggered-Delay Hit Line Merger

This block gathers a wide bus of single-bit detector hit lines onto a few output lines. Each output can then feed one multi-hit time-to-digital channel, which records the arrival times of several inputs at once. The inputs are split into groups of four or five. Inside a group, every position gets a fixed delay that is a distinct integer multiple of a base step. Delays are clocked shift registers, and the base step is the parameter `STEP_CYCLES`. Six cycles at a 40 MHz logic clock gives a 150 ns step. Adjusting the parameter moves the step in 25 ns increments around that value. The delayed lines of a group are ORed together, so hits from different positions land on one wire but at separated times.

With the default parameters the block maps 36 inputs onto 8 outputs. Four groups of four use delays 0, T, 2T and 3T. Four groups of five use delays 0, T, 2T, 3T and 4T. Each input has an enable bit. The enable bits are loaded through a byte-wide write port. Only enabled inputs are captured, and after reset every input is disabled. Masking is applied where a hit is captured, before the delay, so a hit that is already inside a delay line always finishes its trip.

The datapath has no state machine. Its stages are a capture register, the per-position shift registers, and the output register.

Top module: `stagger_mux`

## Requirements
- R1: After reset every output `merged_o` bit is 0, every enable bit is 0, and a hit on any input produces no output until that input is enabled.
- R2: A hit on position k of a group, sampled at clock edge e, drives that group's output high after edge e + k*STEP_CYCLES + 1. With the default step, the latencies are 1, 7, 13, 19 and 25 cycles.
- R3: Groups 0 to 3 each hold four inputs, with group g covering inputs 4g to 4g+3. Groups 4 to 7 each hold five inputs, with group g covering inputs 16+5(g-4) to 20+5(g-4). The position inside a group is the input's offset from the first input of that group. A hit never appears on another group's output.
- R4: Simultaneous hits on different positions of one group appear as separate pulses when their delayed copies do not overlap. Where the delayed copies overlap, they merge into one continuous high.
- R5: An input whose enable bit is 0 is not captured, and its group output stays low for that hit.
- R6: Clearing an input's enable bit does not cancel a hit already captured. That hit still appears at its normal latency.
- R7: A write stores `wr_data` bit b as the enable of input 8*`wr_addr`+b. Bits that map to input 36 or above are ignored, and writes to addresses 5, 6 and 7 change nothing.
- R8: A hit held high for N consecutive sampled cycles produces an output pulse exactly N cycles long, at the same latency as R2.
- R9: A write that lands on the same edge as a hit does not apply to that hit. The new enable value governs hits sampled from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Enable-register write strobe |
| wr_addr | input | 3 | Enable word index |
| wr_data | input | 8 | Enable bits for eight consecutive inputs |
| hit_i | input | 36 | Detector hit lines |
| merged_o | output | 8 | One time-multiplexed line per group |

## Verification
Two things can meet on one clock edge: an update to the enable bits and the capture of a hit on the input being updated. The bench raises the write strobe together with the first sampled cycle of a hit on a disabled input and expects no pulse at all. It also issues a disabling write one edge after a capture and expects the pulse to arrive untouched 25 cycles later. Both cases are judged by recording the group's output cycle by cycle and comparing it with the trace expected from the latency and enable-timing rules.

// File: rtl/stagger_pkg.sv
`timescale 1ns/1ps
package stagger_pkg;

    // Number of inputs in group g: the short groups come first.
    function automatic int grp_size(input int g, input int n_short,
                                    input int short_sz, input int long_sz);
        return (g < n_short) ? short_sz : long_sz;
    endfunction

    // Index of the first input of group g on the flat hit bus.
    function automatic int grp_base(input int g, input int n_short,
                                    input int short_sz, input int long_sz);
        if (g < n_short)
            return g * short_sz;
        return n_short * short_sz + (g - n_short) * long_sz;
    endfunction

endpackage

// File: rtl/stagger_enable_bank.sv
`timescale 1ns/1ps
module stagger_enable_bank #(
    parameter int N_CH   = 36,
    parameter int WORD_W = 8,
    parameter int WORDS  = 5,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [N_CH-1:0]   enable_o
);

    logic [N_CH-1:0] en_q;

    // One flop per existing input; bits beyond N_CH simply have no storage.
    for (genvar i = 0; i < N_CH; i++) begin : g_bit
        localparam int WIDX = i / WORD_W;
        localparam int BIDX = i % WORD_W;
        always_ff @(posedge clk) begin
            if (rst)
                en_q[i] <= 1'b0;
            else if (wr_en && (wr_addr == ADDR_W'(WIDX)))
                en_q[i] <= wr_data[BIDX];
        end
    end

    assign enable_o = en_q;

    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(enable_o));

    a_r7_out_of_range_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr >= ADDR_W'(WORDS))) |=> $stable(enable_o));

endmodule

// File: rtl/stagger_delay_line.sv
`timescale 1ns/1ps
module stagger_delay_line #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    if (DEPTH == 0) begin : g_pass
        logic unused_ctl;
        assign unused_ctl = clk ^ rst;
        assign dout = din;
    end else if (DEPTH == 1) begin : g_one
        logic sr_q;
        always_ff @(posedge clk) begin
            if (rst) sr_q <= 1'b0;
            else     sr_q <= din;
        end
        assign dout = sr_q;
    end else begin : g_chain
        logic [DEPTH-1:0] sr_q;
        always_ff @(posedge clk) begin
            if (rst) sr_q <= '0;
            else     sr_q <= {sr_q[DEPTH-2:0], din};
        end
        assign dout = sr_q[DEPTH-1];
    end

endmodule

// File: rtl/stagger_group.sv
`timescale 1ns/1ps
module stagger_group #(
    parameter  int SIZE  = 4,
    parameter  int STEP  = 6,
    localparam int MAXD  = (SIZE - 1) * STEP,
    localparam int QLIM  = MAXD + 2,
    localparam int QW    = $clog2(QLIM + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SIZE-1:0] hits_i,
    output logic            merged_o
);

    logic [SIZE-1:0] taps;
    logic            merged_q;

    // Position k of the group is delayed by k base steps.
    for (genvar k = 0; k < SIZE; k++) begin : g_pos
        stagger_delay_line #(.DEPTH(k * STEP)) u_line (
            .clk  (clk),
            .rst  (rst),
            .din  (hits_i[k]),
            .dout (taps[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) merged_q <= 1'b0;
        else     merged_q <= |taps;
    end

    assign merged_o = merged_q;

    // Checker state: cycles since the group last captured anything.
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk) begin
        if (rst)
            quiet_q <= QW'(QLIM);
        else if (|hits_i)
            quiet_q <= '0;
        else if (quiet_q != QW'(QLIM))
            quiet_q <= quiet_q + 1'b1;
    end

    // R2: nothing can leave the group once its longest delay has drained.
    a_r2_drain_bound: assert property (@(posedge clk) disable iff (rst)
        (quiet_q >= QW'(MAXD + 1)) |-> !merged_o);

endmodule

// File: rtl/stagger_mux.sv
`timescale 1ns/1ps
module stagger_mux #(
    parameter  int N_SHORT     = 4,
    parameter  int N_LONG      = 4,
    parameter  int SHORT_SZ    = 4,
    parameter  int LONG_SZ     = 5,
    parameter  int STEP_CYCLES = 6,
    parameter  int WORD_W      = 8,
    localparam int N_GRP       = N_SHORT + N_LONG,
    localparam int N_CH        = N_SHORT * SHORT_SZ + N_LONG * LONG_SZ,
    localparam int WORDS       = (N_CH + WORD_W - 1) / WORD_W,
    localparam int ADDR_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [N_CH-1:0]   hit_i,
    output logic [N_GRP-1:0]  merged_o
);

    logic [N_CH-1:0] enable;
    logic [N_CH-1:0] hit_q;

    stagger_enable_bank #(
        .N_CH   (N_CH),
        .WORD_W (WORD_W),
        .WORDS  (WORDS),
        .ADDR_W (ADDR_W)
    ) u_enable (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .enable_o (enable)
    );

    // Capture stage: masking happens here, ahead of every delay.
    always_ff @(posedge clk) begin
        if (rst) hit_q <= '0;
        else     hit_q <= hit_i & enable;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam int SZ   = stagger_pkg::grp_size(g, N_SHORT, SHORT_SZ, LONG_SZ);
        localparam int BASE = stagger_pkg::grp_base(g, N_SHORT, SHORT_SZ, LONG_SZ);
        stagger_group #(.SIZE(SZ), .STEP(STEP_CYCLES)) u_group (
            .clk      (clk),
            .rst      (rst),
            .hits_i   (hit_q[BASE +: SZ]),
            .merged_o (merged_o[g])
        );
    end

    // R1: outputs leave reset low.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (merged_o == '0));

    // R5: a disabled input is never captured.
    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        a_r5_disabled_not_captured: assert property (@(posedge clk) disable iff (rst)
            !enable[i] |=> !hit_q[i]);
    end

endmodule

// File: tb/stagger_mux_bench.sv
`timescale 1ns/1ps
module stagger_mux_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [35:0] hit = '0;
    logic [7:0]  out;

    int n_total = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    stagger_mux u_stagger_mux (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hit_i    (hit),
        .merged_o (out)
    );

    // Vector table: input, expected group, expected latency (step 6).
    localparam int NV = 10;
    localparam int VCH[NV]  = '{0, 3, 5, 15, 16, 20, 27, 35, 10, 33};
    localparam int VGRP[NV] = '{0, 0, 1, 3,  4,  4,  6,  7,  2,  7};
    localparam int VLAT[NV] = '{1, 19, 7, 19, 1, 25, 7, 25, 13, 13};

    function automatic logic [47:0] expect_tr(input int lat, input int w);
        logic [47:0] e = '0;
        for (int t = lat; t < lat + w; t++) e[t] = 1'b1;
        return e;
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_en(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive pat for w sampled cycles, record group g for 48 cycles.
    // A write issued at wr_t is sampled on the same edge as hit cycle wr_t.
    task automatic run_trace(input logic [35:0] pat, input int w, input int g,
                             input int wr_t, input logic [2:0] a, input logic [7:0] d,
                             output logic [47:0] tr, output logic leak);
        @(negedge clk);
        hit = pat; tr = '0; leak = 1'b0;
        for (int t = 0; t < 48; t++) begin
            if (t == wr_t) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
            else wr_en = 1'b0;
            @(negedge clk);
            if (t == w - 1) hit = '0;
            tr[t] = out[g];
            if ((out & ~(8'b1 << g)) != 8'b0) leak = 1'b1;
        end
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_total++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        logic [47:0] tr;
        logic        lk;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", {40'b0, out}, 48'b0);
        run_trace(36'b1, 1, 0, -1, 3'd0, 8'h00, tr, lk);
        check("R1 input disabled after reset", tr, 48'b0);

        for (int a = 0; a < 5; a++) write_en(3'(a), 8'hFF);

        for (int v = 0; v < NV; v++) begin
            run_trace(36'b1 << VCH[v], 1, VGRP[v], -1, 3'd0, 8'h00, tr, lk);
            check($sformatf("R2 latency input %0d", VCH[v]), tr, expect_tr(VLAT[v], 1));
            check($sformatf("R3 no leak input %0d", VCH[v]), {47'b0, lk}, 48'b0);
        end

        run_trace(36'b1 << 10, 4, 2, -1, 3'd0, 8'h00, tr, lk);
        check("R8 held hit width", tr, expect_tr(13, 4));

        run_trace((36'b1 << 16) | (36'b1 << 17), 1, 4, -1, 3'd0, 8'h00, tr, lk);
        check("R4 separated pulses", tr, expect_tr(1, 1) | expect_tr(7, 1));
        run_trace((36'b1 << 16) | (36'b1 << 17), 7, 4, -1, 3'd0, 8'h00, tr, lk);
        check("R4 overlapping pulses merge", tr, expect_tr(1, 13));

        write_en(3'd4, 8'hF0);
        run_trace(36'b1 << 35, 1, 7, -1, 3'd0, 8'h00, tr, lk);
        check("R7 word 4 low bits clear input 35", tr, 48'b0);
        run_trace(36'b1 << 31, 1, 7, -1, 3'd0, 8'h00, tr, lk);
        check("R7 input 31 untouched", tr, expect_tr(1, 1));
        write_en(3'd5, 8'h00);
        write_en(3'd7, 8'h00);
        run_trace(36'b1, 1, 0, -1, 3'd0, 8'h00, tr, lk);
        check("R7 addresses 5 and 7 ignored", tr, expect_tr(1, 1));

        write_en(3'd0, 8'hFE);
        run_trace(36'b1, 1, 0, -1, 3'd0, 8'h00, tr, lk);
        check("R5 disabled input 0 silent", tr, 48'b0);
        run_trace(36'b1 << 1, 1, 0, -1, 3'd0, 8'h00, tr, lk);
        check("R5 neighbour input 1 still live", tr, expect_tr(7, 1));

        run_trace(36'b1 << 20, 1, 4, 1, 3'd2, 8'h00, tr, lk);
        check("R6 in-flight hit survives disable", tr, expect_tr(25, 1));
        run_trace(36'b1 << 20, 1, 4, -1, 3'd0, 8'h00, tr, lk);
        check("R5 input 20 now disabled", tr, 48'b0);

        run_trace(36'b1 << 20, 1, 4, 0, 3'd2, 8'hFF, tr, lk);
        check("R9 same-edge enable not applied", tr, 48'b0);
        run_trace(36'b1 << 20, 1, 4, -1, 3'd0, 8'h00, tr, lk);
        check("R9 enable applies to next hit", tr, expect_tr(25, 1));

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule